// File: doc/BRIEF.md
# Dual-Channel UART Sleep Controller

This block decides, for each of two UART channels, when the channel may stop its clock and when it must start it again. Software sets a per-channel enable bit in a shared 8-bit control byte. While that bit is set, the channel falls asleep as soon as it has nothing to do: its transmitter is drained, no received byte is waiting, its receive line rests at the idle level for the current line mode, no modem-line change is pending and no interrupt is outstanding.

A sleeping channel wakes on any of three kinds of activity. The first is the leading edge of a start bit on its receive line, whose direction depends on the infrared mode. The second is a byte being loaded for transmission. The third is a change on a modem line. On waking it can post a wake-up interrupt that names no particular source. Once every interrupt cause of that channel has been serviced, it goes back to sleep by itself. All interrupt causes of both channels are merged into one host request, which a global disable input can block.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: The control byte `sleep_reg` resets to 0x00. A write with `cfg_wr_ch` = N loads only bit N, taken from `cfg_wr_data[N]`. The other channel's bit is left as it was, and bits 7:2 always read 0.
- R2: A channel enters sleep (`sleep_ind` = 1, `clk_en` = 0) one clock after all of these hold together: its enable bit is 1, `lsr_temt` = 1, `lsr_dr` = 0, no modem delta flag is set, `irq_pend` = 0 and no wake flag is set. While any one of them fails, the channel stays awake.
- R3: Sleep entry also needs the synchronized receive line at its idle level. The idle level is 1 when `ir_mode` = 0 and 0 when `ir_mode` = 1.
- R4: A start-bit edge on `rx_pin` wakes a sleeping channel. The edge is 1-to-0 in normal mode and 0-to-1 in infrared mode. Because of the two-flop synchronizer and the edge register, `sleep_ind` drops within three clocks of the pin change.
- R5: When `mdrop_en` = 0 and `rx_dis` = 1, a start-bit edge does not wake the channel. With `mdrop_en` = 1, the same edge wakes it.
- R6: A one-cycle `tx_load` pulse wakes a sleeping channel on the next clock.
- R7: The modem delta flags sit in `msr_delta[4c+3:4c]`, with bit 0 for clear-to-send, bit 1 for data-set-ready, bit 2 for ring and bit 3 for carrier. Any change on lines 0, 1 and 3 sets the matching flag, but line 2 sets its flag only on a 0-to-1 transition. A newly set flag wakes the channel. A falling ring line neither sets a flag nor wakes it. `msr_rd` clears the flags.
- R8: Leaving sleep on a wake event sets the sticky `wake_irq` flag, unless `wake_irq_dis` = 1. The flag clears on an `iir_rd` pulse.
- R9: `host_irq` is 1 while any channel has a wake flag, a delta flag or `irq_pend` set, except that it is forced to 0 while `gbl_irq_dis` = 1.
- R10: After a wake, the channel returns to sleep on its own once its wake flag, delta flags and `irq_pend` are all clear and the entry conditions hold again. Clearing the enable bit brings it out of sleep within two clocks of the write.
- R11: A wake event on one channel leaves the other channel's sleep state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the control byte |
| cfg_wr_ch | input | 1 | Channel issuing the write |
| cfg_wr_data | input | 8 | Write data |
| wake_irq_dis | input | 1 | 1 suppresses wake-up interrupts |
| gbl_irq_dis | input | 1 | 1 blocks the host interrupt |
| lsr_temt | input | 2 | Per channel: transmitter fully empty |
| lsr_dr | input | 2 | Per channel: receive data waiting |
| rx_pin | input | 2 | Per channel: receive line (asynchronous) |
| ir_mode | input | 2 | Per channel: infrared line mode |
| modem_pin | input | 8 | Per channel four modem line levels (asynchronous) |
| tx_load | input | 2 | Per channel: byte loaded into transmitter |
| mdrop_en | input | 2 | Per channel: multidrop mode on |
| rx_dis | input | 2 | Per channel: receiver disabled |
| irq_pend | input | 2 | Per channel: other interrupt cause pending |
| msr_rd | input | 2 | Per channel: modem status read, clears delta flags |
| iir_rd | input | 2 | Per channel: interrupt identification read, clears wake flag |
| sleep_reg | output | 8 | Control byte readback |
| sleep_ind | output | 2 | Per channel: asleep |
| clk_en | output | 2 | Per channel: clock enable (inverse of sleep) |
| wake_irq | output | 2 | Per channel: sticky wake-up interrupt flag |
| msr_delta | output | 8 | Per channel four modem delta flags |
| host_irq | output | 1 | Gated interrupt request to the host |

## Verification
Entry is tried by holding all idle conditions and then spoiling exactly one of them: pending data, a busy transmitter, a pending interrupt, or a receive line away from its idle level. This shows that each condition blocks entry on its own. Wake-up is driven by a falling receive edge in normal mode and a rising one in infrared mode, by a transmit load pulse, and by rising and falling changes on the clear-to-send and ring lines. These patterns tell the polarity handling and the ring-only-rising rule apart from a plain change detector. The multidrop/receiver-disable pair is driven to both its blocking and its non-blocking combination. The wake interrupt mask, the global gate and a wake on one channel while the other sleeps separate the interrupt path from the sleep state itself.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE     = 2'd0,
        ST_SLEEP     = 2'd1,
        ST_WAKE_PEND = 2'd2
    } slp_state_e;

    localparam int MDM_CTS = 0;
    localparam int MDM_DSR = 1;
    localparam int MDM_RI  = 2;
    localparam int MDM_CD  = 3;
    localparam int MDM_W   = 4;

    // Sources able to bring a channel out of sleep
    typedef struct packed {
        logic start_edge;
        logic tx_load;
        logic modem;
    } wake_src_t;

    // Conditions that must all be true before a channel may sleep
    typedef struct packed {
        logic enabled;
        logic tx_empty;
        logic rx_empty;
        logic rx_idle;
        logic no_delta;
        logic no_irq;
    } idle_view_t;

    function automatic logic rx_idle_level(input logic ir);
        return ~ir;
    endfunction

    function automatic logic start_edge_seen(input logic prev, input logic cur, input logic ir);
        return (prev == rx_idle_level(ir)) && (cur != rx_idle_level(ir));
    endfunction

    function automatic logic start_blocked(input logic mdrop, input logic rxoff);
        return ~mdrop & rxoff;
    endfunction

    // New delta bits: any change, ring line on rising edge only
    function automatic logic [MDM_W-1:0] delta_new(input logic [MDM_W-1:0] prev,
                                                   input logic [MDM_W-1:0] cur);
        logic [MDM_W-1:0] d;
        d = prev ^ cur;
        d[MDM_RI] = ~prev[MDM_RI] & cur[MDM_RI];
        return d;
    endfunction

    function automatic logic all_idle(input idle_view_t v);
        return &v;
    endfunction

endpackage

// File: rtl/uart_sleep_sync.sv
module uart_sleep_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_sleep_modem_delta.sv
module uart_sleep_modem_delta
    import uart_sleep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [MDM_W-1:0] lvl,
    input  logic             clr,
    output logic [MDM_W-1:0] delta,
    output logic             set_pulse
);
    logic [MDM_W-1:0] prev_q;
    logic [MDM_W-1:0] delta_q;
    logic [MDM_W-1:0] fresh;

    assign fresh = delta_new(prev_q, lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            delta_q <= '0;
        end else begin
            prev_q  <= lvl;
            delta_q <= clr ? fresh : (delta_q | fresh);
        end
    end

    assign delta     = delta_q;
    assign set_pulse = |fresh;
endmodule

// File: rtl/uart_sleep_fsm.sv
module uart_sleep_fsm
    import uart_sleep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tx_empty,
    input  logic rx_ready,
    input  logic rx_lvl,
    input  logic ir_mode,
    input  logic mdrop_en,
    input  logic rx_dis,
    input  logic tx_load,
    input  logic delta_any,
    input  logic delta_set,
    input  logic irq_pend,
    input  logic iir_rd,
    input  logic wake_irq_dis,
    output logic sleep_o,
    output logic wake_flag_o
);
    slp_state_e state_q, state_d;
    logic       rx_prev_q;
    logic       flag_q;
    wake_src_t  src;
    idle_view_t view;
    logic       wake_ev;
    logic       causes_clear;

    always_comb begin
        src.start_edge = start_edge_seen(rx_prev_q, rx_lvl, ir_mode)
                       & ~start_blocked(mdrop_en, rx_dis);
        src.tx_load    = tx_load;
        src.modem      = delta_set;
    end

    assign wake_ev      = |src;
    assign causes_clear = ~flag_q & ~irq_pend & ~delta_any;

    always_comb begin
        view.enabled  = en;
        view.tx_empty = tx_empty;
        view.rx_empty = ~rx_ready;
        view.rx_idle  = (rx_lvl == rx_idle_level(ir_mode));
        view.no_delta = ~delta_any;
        view.no_irq   = causes_clear & ~wake_ev;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE:     if (all_idle(view)) state_d = ST_SLEEP;
            ST_SLEEP:     if (!en) state_d = ST_AWAKE;
                          else if (wake_ev) state_d = ST_WAKE_PEND;
            ST_WAKE_PEND: if (!en || causes_clear) state_d = ST_AWAKE;
            default:      state_d = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_AWAKE;
            rx_prev_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            rx_prev_q <= rx_lvl;
            if (state_q == ST_SLEEP && state_d == ST_WAKE_PEND && !wake_irq_dis)
                flag_q <= 1'b1;
            else if (iir_rd)
                flag_q <= 1'b0;
        end
    end

    assign sleep_o     = (state_q == ST_SLEEP);
    assign wake_flag_o = flag_q;
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
    import uart_sleep_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int MDM_BITS   = NUM_CH * MDM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr_en,
    input  logic [CH_W-1:0]     cfg_wr_ch,
    input  logic [REG_W-1:0]    cfg_wr_data,
    input  logic                wake_irq_dis,
    input  logic                gbl_irq_dis,
    input  logic [NUM_CH-1:0]   lsr_temt,
    input  logic [NUM_CH-1:0]   lsr_dr,
    input  logic [NUM_CH-1:0]   rx_pin,
    input  logic [NUM_CH-1:0]   ir_mode,
    input  logic [MDM_BITS-1:0] modem_pin,
    input  logic [NUM_CH-1:0]   tx_load,
    input  logic [NUM_CH-1:0]   mdrop_en,
    input  logic [NUM_CH-1:0]   rx_dis,
    input  logic [NUM_CH-1:0]   irq_pend,
    input  logic [NUM_CH-1:0]   msr_rd,
    input  logic [NUM_CH-1:0]   iir_rd,
    output logic [REG_W-1:0]    sleep_reg,
    output logic [NUM_CH-1:0]   sleep_ind,
    output logic [NUM_CH-1:0]   clk_en,
    output logic [NUM_CH-1:0]   wake_irq,
    output logic [MDM_BITS-1:0] msr_delta,
    output logic                host_irq
);
    logic [REG_W-1:0]  reg_q;
    logic [NUM_CH-1:0] delta_any;
    logic              unused_wr_hi;

    assign unused_wr_hi = ^cfg_wr_data[REG_W-1:NUM_CH];

    // Each channel may only load its own enable bit
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (cfg_wr_en) begin
            for (int c = 0; c < NUM_CH; c++)
                if (cfg_wr_ch == CH_W'(c)) reg_q[c] <= cfg_wr_data[c];
        end
    end

    assign sleep_reg = reg_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [MDM_W:0]   sync_q;
        logic [MDM_W-1:0] dlt;
        logic             dlt_set;

        uart_sleep_sync #(.W(MDM_W + 1), .STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   ({modem_pin[c*MDM_W +: MDM_W], rx_pin[c]}),
            .q   (sync_q)
        );

        uart_sleep_modem_delta u_delta (
            .clk       (clk),
            .rst       (rst),
            .lvl       (sync_q[MDM_W:1]),
            .clr       (msr_rd[c]),
            .delta     (dlt),
            .set_pulse (dlt_set)
        );

        assign delta_any[c]                 = |dlt;
        assign msr_delta[c*MDM_W +: MDM_W]  = dlt;

        uart_sleep_fsm u_fsm (
            .clk          (clk),
            .rst          (rst),
            .en           (reg_q[c]),
            .tx_empty     (lsr_temt[c]),
            .rx_ready     (lsr_dr[c]),
            .rx_lvl       (sync_q[0]),
            .ir_mode      (ir_mode[c]),
            .mdrop_en     (mdrop_en[c]),
            .rx_dis       (rx_dis[c]),
            .tx_load      (tx_load[c]),
            .delta_any    (delta_any[c]),
            .delta_set    (dlt_set),
            .irq_pend     (irq_pend[c]),
            .iir_rd       (iir_rd[c]),
            .wake_irq_dis (wake_irq_dis),
            .sleep_o      (sleep_ind[c]),
            .wake_flag_o  (wake_irq[c])
        );
    end

    assign clk_en   = ~sleep_ind;
    assign host_irq = ~gbl_irq_dis & (|(wake_irq | irq_pend | delta_any));
endmodule

// File: rtl/uart_sleep_ctrl_chk.sv
module uart_sleep_ctrl_chk #(
    parameter int NUM_CH = 2,
    parameter int REG_W  = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic [CH_W-1:0]   cfg_wr_ch,
    input logic [REG_W-1:0]  sleep_reg,
    input logic [NUM_CH-1:0] sleep_ind,
    input logic [NUM_CH-1:0] lsr_temt,
    input logic [NUM_CH-1:0] lsr_dr,
    input logic [NUM_CH-1:0] tx_load,
    input logic [NUM_CH-1:0] wake_irq,
    input logic              wake_irq_dis
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_WRITE_OWN_BIT: assert property (@(posedge clk) disable iff (rst)
            cfg_wr_en && (cfg_wr_ch != CH_W'(c)) |=> $stable(sleep_reg[c])); // R1

        AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (rst)
            $rose(sleep_ind[c]) |-> $past(sleep_reg[c]) && $past(lsr_temt[c]) && !$past(lsr_dr[c])); // R2

        AST_TXLOAD_WAKES: assert property (@(posedge clk) disable iff (rst)
            sleep_ind[c] && tx_load[c] && sleep_reg[c] |=> !sleep_ind[c]); // R6

        AST_WAKE_FLAG_MASKED: assert property (@(posedge clk) disable iff (rst)
            $rose(wake_irq[c]) |-> !$past(wake_irq_dis)); // R8

        AST_DISABLE_LEAVES: assert property (@(posedge clk) disable iff (rst)
            !sleep_reg[c] |=> !sleep_ind[c]); // R10
    end
endmodule

bind uart_sleep_ctrl uart_sleep_ctrl_chk #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_ch    (cfg_wr_ch),
    .sleep_reg    (sleep_reg),
    .sleep_ind    (sleep_ind),
    .lsr_temt     (lsr_temt),
    .lsr_dr       (lsr_dr),
    .tx_load      (tx_load),
    .wake_irq     (wake_irq),
    .wake_irq_dis (wake_irq_dis)
);

// File: tb/uart_sleep_ctrl_tb.sv
module uart_sleep_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr_en = 1'b0;
    logic [0:0] cfg_wr_ch = '0;
    logic [7:0] cfg_wr_data = '0;
    logic       wake_irq_dis = 1'b0;
    logic       gbl_irq_dis = 1'b0;
    logic [1:0] lsr_temt = 2'b11;
    logic [1:0] lsr_dr = 2'b00;
    logic [1:0] rx_pin = 2'b11;
    logic [1:0] ir_mode = 2'b00;
    logic [7:0] modem_pin = '0;
    logic [1:0] tx_load = '0;
    logic [1:0] mdrop_en = '0;
    logic [1:0] rx_dis = '0;
    logic [1:0] irq_pend = '0;
    logic [1:0] msr_rd = '0;
    logic [1:0] iir_rd = '0;
    logic [7:0] sleep_reg;
    logic [1:0] sleep_ind;
    logic [1:0] clk_en;
    logic [1:0] wake_irq;
    logic [7:0] msr_delta;
    logic       host_irq;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    uart_sleep_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_ch(cfg_wr_ch),
        .cfg_wr_data(cfg_wr_data), .wake_irq_dis(wake_irq_dis), .gbl_irq_dis(gbl_irq_dis),
        .lsr_temt(lsr_temt), .lsr_dr(lsr_dr), .rx_pin(rx_pin), .ir_mode(ir_mode),
        .modem_pin(modem_pin), .tx_load(tx_load), .mdrop_en(mdrop_en), .rx_dis(rx_dis),
        .irq_pend(irq_pend), .msr_rd(msr_rd), .iir_rd(iir_rd), .sleep_reg(sleep_reg),
        .sleep_ind(sleep_ind), .clk_en(clk_en), .wake_irq(wake_irq),
        .msr_delta(msr_delta), .host_irq(host_irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [7:0] data);
        cfg_wr_en = 1'b1; cfg_wr_ch = 1'(ch); cfg_wr_data = data;
        step(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic clear_irq(input int ch);
        iir_rd[ch] = 1'b1; msr_rd[ch] = 1'b1;
        step(1);
        iir_rd[ch] = 1'b0; msr_rd[ch] = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset reg", 32'(sleep_reg), 32'h00);
        chk("R2 reset awake", 32'(sleep_ind), 32'h0);
        chk("R2 reset clk_en", 32'(clk_en), 32'h3);
        chk("R9 reset host_irq", 32'(host_irq), 32'h0);
    endtask

    task automatic t_write_rule;
        wr(0, 8'hFF);  chk("R1 ch0 writes FF", 32'(sleep_reg), 32'h01);
        wr(1, 8'hFE);  chk("R1 ch1 sets own bit", 32'(sleep_reg), 32'h03);
        wr(1, 8'h01);  chk("R1 ch1 clears own bit only", 32'(sleep_reg), 32'h01);
        wr(0, 8'h02);  chk("R1 ch0 clears own bit only", 32'(sleep_reg), 32'h00);
        step(2);
    endtask

    task automatic t_entry;
        lsr_dr[0] = 1'b1;
        wr(0, 8'h01); step(4);
        chk("R2 data waiting blocks", 32'(sleep_ind[0]), 32'h0);
        lsr_dr[0] = 1'b0; lsr_temt[0] = 1'b0; step(4);
        chk("R2 busy tx blocks", 32'(sleep_ind[0]), 32'h0);
        irq_pend[0] = 1'b1; lsr_temt[0] = 1'b1; step(4);
        chk("R2 pending irq blocks", 32'(sleep_ind[0]), 32'h0);
        chk("R9 pending irq raises host_irq", 32'(host_irq), 32'h1);
        irq_pend[0] = 1'b0; step(1);
        chk("R2 entry one clock later", 32'(sleep_ind[0]), 32'h1);
        chk("R2 clk_en low", 32'(clk_en[0]), 32'h0);
    endtask

    task automatic t_disable;
        wr(0, 8'h00); step(1);
        chk("R10 disable exits sleep", 32'(sleep_ind[0]), 32'h0);
        step(2);
    endtask

    task automatic t_ir_mode;
        ir_mode[0] = 1'b1; rx_pin[0] = 1'b1;
        wr(0, 8'h01); step(6);
        chk("R3 ir high not idle", 32'(sleep_ind[0]), 32'h0);
        rx_pin[0] = 1'b0; step(4);
        chk("R3 ir low idle", 32'(sleep_ind[0]), 32'h1);
        rx_pin[0] = 1'b1; step(4);
        chk("R4 ir rising start wakes", 32'(sleep_ind[0]), 32'h0);
        chk("R8 wake flag set", 32'(wake_irq[0]), 32'h1);
        clear_irq(0);
        wr(0, 8'h00); ir_mode[0] = 1'b0; step(4);
    endtask

    task automatic t_normal_start;
        wr(0, 8'h01); step(3);
        chk("R3 normal high idle", 32'(sleep_ind[0]), 32'h1);
        rx_pin[0] = 1'b0; step(4);
        chk("R4 falling start wakes", 32'(sleep_ind[0]), 32'h0);
        chk("R9 wake raises host_irq", 32'(host_irq), 32'h1);
        gbl_irq_dis = 1'b1; step(1);
        chk("R9 global disable blocks", 32'(host_irq), 32'h0);
        gbl_irq_dis = 1'b0;
        clear_irq(0); rx_pin[0] = 1'b1; step(5);
        chk("R10 auto re-entry", 32'(sleep_ind[0]), 32'h1);
        chk("R8 flag cleared by read", 32'(wake_irq[0]), 32'h0);
    endtask

    task automatic t_multidrop;
        rx_dis[0] = 1'b1; mdrop_en[0] = 1'b0;
        rx_pin[0] = 1'b0; step(5);
        chk("R5 blocked start keeps sleep", 32'(sleep_ind[0]), 32'h1);
        chk("R5 blocked start no flag", 32'(wake_irq[0]), 32'h0);
        rx_pin[0] = 1'b1; step(4);
        mdrop_en[0] = 1'b1; rx_pin[0] = 1'b0; step(4);
        chk("R5 multidrop on wakes", 32'(sleep_ind[0]), 32'h0);
        rx_pin[0] = 1'b1; mdrop_en[0] = 1'b0; rx_dis[0] = 1'b0;
        clear_irq(0); step(4);
    endtask

    task automatic t_tx_load;
        wr(1, 8'h02); step(3);
        chk("R11 ch1 asleep", 32'(sleep_ind[1]), 32'h1);
        chk("R10 ch0 asleep again", 32'(sleep_ind[0]), 32'h1);
        tx_load[0] = 1'b1; step(1); tx_load[0] = 1'b0;
        chk("R6 tx load wakes", 32'(sleep_ind[0]), 32'h0);
        chk("R11 ch1 untouched", 32'(sleep_ind[1]), 32'h1);
        step(1);
        chk("R8 flag after tx wake", 32'(wake_irq), 32'h1);
        clear_irq(0); step(3);
    endtask

    task automatic t_mask;
        wake_irq_dis = 1'b1;
        tx_load[0] = 1'b1; step(1); tx_load[0] = 1'b0;
        chk("R8 masked wake no flag", 32'(wake_irq[0]), 32'h0);
        chk("R9 masked wake no host_irq", 32'(host_irq), 32'h0);
        step(3);
        chk("R10 masked wake re-enters", 32'(sleep_ind[0]), 32'h1);
        wake_irq_dis = 1'b0;
    endtask

    task automatic t_modem;
        modem_pin[0] = 1'b1; step(4);
        chk("R7 cts rise wakes", 32'(sleep_ind[0]), 32'h0);
        chk("R7 cts delta bit0", 32'(msr_delta[3:0]), 32'h1);
        clear_irq(0); step(3);
        chk("R7 delta cleared, asleep", 32'({msr_delta[3:0], 3'b0, sleep_ind[0]}), 32'h1);
        modem_pin[0] = 1'b0; step(4);
        chk("R7 cts fall sets delta", 32'(msr_delta[3:0]), 32'h1);
        clear_irq(0); step(3);
        modem_pin[2] = 1'b1; step(4);
        chk("R7 ring rise wakes", 32'({msr_delta[3:0], 3'b0, sleep_ind[0]}), 32'h40);
        clear_irq(0); step(3);
        chk("R7 asleep with ring high", 32'(sleep_ind[0]), 32'h1);
        modem_pin[2] = 1'b0; step(5);
        chk("R7 ring fall no wake", 32'(sleep_ind[0]), 32'h1);
        chk("R7 ring fall no delta", 32'(msr_delta[3:0]), 32'h0);
        chk("R11 ch1 still asleep", 32'(sleep_ind[1]), 32'h1);
    endtask

    initial begin
        step(5);
        rst = 1'b0;
        step(4);
        t_reset();
        t_write_rule();
        t_entry();
        t_disable();
        t_ir_mode();
        t_normal_start();
        t_multidrop();
        t_tx_load();
        t_mask();
        t_modem();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule